// File: doc/BRIEF.md
# DRAM Refresh and Bring-up Scheduler

This block keeps an asynchronous DRAM alive and brings it up after power-on. Once reset is released it waits a programmable start-up time. It then runs a fixed number of refresh cycles on its own and raises a ready flag. After that it asks a separate access controller for the strobes at a fixed refresh interval. Each granted slot becomes one CAS-before-RAS refresh, which needs no address because the memory steps its own row counter.

Every timing limit is given as a parameter in nanoseconds. It is turned into whole clock cycles by rounding up against the clock period parameter. Refresh intervals that expire before the controller grants a slot are kept as a debt in a small counter. The owed refreshes are then served back to back, up to the capacity of that counter.

The request/grant pair behaves like a valid/ready pair. Once the request is raised it is held until a clock edge sees the grant high. The controller may keep the grant low for as long as it likes. A grant seen while the request is low does nothing. The done pulse tells the controller that the strobes are free again.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is low, `ras_n`, `lcas_n` and `ucas_n` are high, and `ref_req`, `ref_done` and `init_ready` are low.
- R2: `init_ready` rises exactly PW + INIT_REFS*P clock edges after reset release and then stays high. PW is the rounded start-up wait. P is 1 + CSR + max(RAS, CHR) + RP, with each term in rounded cycles. Exactly INIT_REFS refresh sequences happen before it rises, and `ref_req` stays low until it rises.
- R3: In every refresh, `lcas_n` and `ucas_n` are equal, and both are low for at least CSR cycles before `ras_n` falls.
- R4: `ras_n` stays low for at least max(RAS, CHR) cycles, and both CAS strobes stay low for that whole time.
- R5: After `ras_n` rises, the CAS strobes stay low for at least RPC cycles before going high. `ras_n` stays high for at least RP cycles before it falls again.
- R6: Once ready, one refresh falls due every INT cycles. The first falls due INT cycles after ready rises. With no backlog and the strobes idle, `ref_req` rises in that same cycle.
- R7: `ref_req` stays high until an edge sees `ref_grant` high. A grant while `ref_req` is low starts nothing.
- R8: A refresh starts in the cycle in which request and grant are both high. `ref_done` is high for exactly one cycle, P-1 cycles after that start cycle, with all strobes high. `ref_req` is low while a refresh is in progress.
- R9: Refreshes that fall due without a grant are counted up to 2^OWED_W-1, and any beyond that are dropped. With the grant held high, the owed refreshes are served back to back, and `ref_req` then falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_req | output | 1 | Refresh wanted (valid) |
| ref_grant | input | 1 | Strobes handed to this block (ready) |
| ref_done | output | 1 | One-cycle pulse at the end of a granted refresh |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| init_ready | output | 1 | Bring-up complete; memory may be accessed |

## Verification
The assertions assume the controller follows the valid/ready contract. The strobe sequencer is therefore started only from idle, and only by the bring-up logic or by an accepted grant. They also assume the rounded timing parameters are at least one cycle each.

The bench drives the grant only from its own tasks. It sweeps the grant latency, raises a grant while no request is pending, and holds the grant off for long stretches. Every one of these grant patterns keeps within the contract above. The strobe order and widths are checked on every refresh, including the bring-up sequences.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_CSR,
    SQ_ACT,
    SQ_RPC,
    SQ_PRE
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_WAIT,
    PH_INIT,
    PH_RUN
  } phase_e;

  // nanoseconds to whole cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/dram_ref_bringup.sv
module dram_ref_bringup
  import dram_ref_pkg::*;
#(
  parameter int PWRUP_CYC = 10000,
  parameter int INIT_REFS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_idle,
  input  logic seq_fin,
  output logic init_start,
  output logic ready
);
  localparam int PW = $clog2(PWRUP_CYC + 1);
  localparam int IW = $clog2(INIT_REFS + 1);

  phase_e        ph;
  logic [PW-1:0] wcnt;
  logic [IW-1:0] icnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= PH_WAIT;
      wcnt <= PW'(PWRUP_CYC - 1);
      icnt <= '0;
    end else begin
      case (ph)
        PH_WAIT: begin
          if (wcnt == '0) ph <= PH_INIT;
          else            wcnt <= wcnt - PW'(1);
        end
        PH_INIT: begin
          if (seq_fin) begin
            if (icnt == IW'(INIT_REFS - 1)) ph <= PH_RUN;
            else                            icnt <= icnt + IW'(1);
          end
        end
        PH_RUN:  ph <= PH_RUN;
        default: ph <= PH_WAIT;
      endcase
    end
  end

  assign ready      = (ph == PH_RUN);
  assign init_start = (ph == PH_INIT) && seq_idle;

  // R2: once the memory is declared usable it stays usable
  a_r2_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);

endmodule

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int INTERVAL = 780,
  parameter int OWED_W   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic take,
  output logic pending
);
  localparam int TW = $clog2(INTERVAL + 1);
  localparam logic [OWED_W-1:0] OMAX = '1;

  logic [TW-1:0]     cnt;
  logic [OWED_W-1:0] owed;
  logic              tick;

  assign tick = en && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= TW'(INTERVAL - 1);
      owed <= '0;
    end else begin
      if (!en || tick) cnt <= TW'(INTERVAL - 1);
      else             cnt <= cnt - TW'(1);
      case ({tick, take})
        2'b10:   if (owed != OMAX) owed <= owed + OWED_W'(1);
        2'b01:   owed <= owed - OWED_W'(1);
        default: owed <= owed;
      endcase
    end
  end

  assign pending = (owed != '0);

  // R9: a refresh is only taken while one is owed
  a_r9_take_needs_debt: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pending);

endmodule

// File: rtl/dram_ref_seq.sv
module dram_ref_seq
  import dram_ref_pkg::*;
#(
  parameter int CSR_C   = 1,
  parameter int ACT_C   = 3,
  parameter int RPC_C   = 1,
  parameter int PRE_C   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic fin,
  output logic ras_n,
  output logic cas_n
);
  localparam int M1   = (CSR_C > ACT_C) ? CSR_C : ACT_C;
  localparam int M2   = (RPC_C > PRE_C) ? RPC_C : PRE_C;
  localparam int MAXL = (M1 > M2) ? M1 : M2;
  localparam int SW   = $clog2(MAXL + 1);

  seq_state_e    st;
  logic [SW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= SQ_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          st  <= SQ_CSR;
          cnt <= SW'(CSR_C - 1);
        end
        SQ_CSR: if (cnt == '0) begin
          st  <= SQ_ACT;
          cnt <= SW'(ACT_C - 1);
        end else cnt <= cnt - SW'(1);
        SQ_ACT: if (cnt == '0) begin
          st  <= SQ_RPC;
          cnt <= SW'(RPC_C - 1);
        end else cnt <= cnt - SW'(1);
        SQ_RPC: if (cnt == '0) begin
          st  <= SQ_PRE;
          cnt <= SW'(PRE_C - 1);
        end else cnt <= cnt - SW'(1);
        SQ_PRE: if (cnt == '0) st <= SQ_IDLE;
                else           cnt <= cnt - SW'(1);
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign idle  = (st == SQ_IDLE);
  assign fin   = (st == SQ_PRE) && (cnt == '0);
  assign ras_n = (st != SQ_ACT);
  assign cas_n = !((st == SQ_CSR) || (st == SQ_ACT) || (st == SQ_RPC));

  // R3: column strobes already low in the cycle before the row strobe falls
  a_r3_cas_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));
  // R5: column strobes release only after the row strobe is back high
  a_r5_cas_after_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> $past(ras_n));
  // R5: row strobe never pulses high for a single cycle
  a_r5_ras_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> ras_n);
  // R8: a new sequence is launched only from idle
  a_r8_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> idle);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int CLK_NS     = 20,
  parameter int PWRUP_NS   = 200000,
  parameter int REF_INT_NS = 15600,
  parameter int T_CSR_NS   = 5,
  parameter int T_CHR_NS   = 10,
  parameter int T_RAS_NS   = 50,
  parameter int T_RP_NS    = 30,
  parameter int T_RPC_NS   = 5,
  parameter int INIT_REFS  = 8,
  parameter int OWED_W     = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_req,
  input  logic ref_grant,
  output logic ref_done,
  output logic ras_n,
  output logic lcas_n,
  output logic ucas_n,
  output logic init_ready
);
  localparam int PWRUP_C = ns2cyc(PWRUP_NS, CLK_NS);
  localparam int INT_C   = ns2cyc(REF_INT_NS, CLK_NS);
  localparam int CSR_C   = ns2cyc(T_CSR_NS, CLK_NS);
  localparam int CHR_C   = ns2cyc(T_CHR_NS, CLK_NS);
  localparam int RAS_C   = ns2cyc(T_RAS_NS, CLK_NS);
  localparam int RP_C    = ns2cyc(T_RP_NS, CLK_NS);
  localparam int RPC_C   = ns2cyc(T_RPC_NS, CLK_NS);
  localparam int ACT_C   = (RAS_C > CHR_C) ? RAS_C : CHR_C;
  localparam int PRE_C   = (RP_C > RPC_C) ? (RP_C - RPC_C) : 1;

  logic seq_idle, seq_fin, seq_start, init_start, pending, take, cas_n;

  assign take      = ref_req && ref_grant;
  assign seq_start = init_start || take;

  dram_ref_bringup #(.PWRUP_CYC(PWRUP_C), .INIT_REFS(INIT_REFS)) u_bringup (
    .clk(clk), .rst_n(rst_n), .seq_idle(seq_idle), .seq_fin(seq_fin),
    .init_start(init_start), .ready(init_ready)
  );

  dram_ref_timer #(.INTERVAL(INT_C), .OWED_W(OWED_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .en(init_ready), .take(take), .pending(pending)
  );

  dram_ref_seq #(.CSR_C(CSR_C), .ACT_C(ACT_C), .RPC_C(RPC_C), .PRE_C(PRE_C)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .idle(seq_idle), .fin(seq_fin),
    .ras_n(ras_n), .cas_n(cas_n)
  );

  assign ref_req  = init_ready && pending && seq_idle;
  assign ref_done = init_ready && seq_fin;
  assign lcas_n   = cas_n;
  assign ucas_n   = cas_n;

  // R2: no request before bring-up has finished
  a_r2_req_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> init_ready);
  // R7: a raised request waits for its grant
  a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_grant) |=> ref_req);
  // R8: done is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> !ref_done);
  // R8: done only with every strobe released
  a_r8_done_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |-> (ras_n && lcas_n && ucas_n));

endmodule

// File: tb/dram_refresh_sched_bench.sv
module dram_refresh_sched_bench;
  localparam int CLK_NS = 20;
  localparam int PWRUP_NS = 500, REF_INT_NS = 800;
  localparam int T_CSR_NS = 5, T_CHR_NS = 70, T_RAS_NS = 50, T_RP_NS = 30, T_RPC_NS = 5;
  localparam int INIT_REFS = 8, OWED_W = 2;

  function automatic int c_of(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int PW_C  = (PWRUP_NS + CLK_NS - 1) / CLK_NS;
  localparam int INT_C = (REF_INT_NS + CLK_NS - 1) / CLK_NS;

  int csr_c, act_c, rp_c, rpc_c, per_c, owed_max;

  logic clk = 0, rst_n = 0, ref_grant = 0;
  logic ref_req, ref_done, ras_n, lcas_n, ucas_n, init_ready;

  dram_refresh_sched #(
    .CLK_NS(CLK_NS), .PWRUP_NS(PWRUP_NS), .REF_INT_NS(REF_INT_NS),
    .T_CSR_NS(T_CSR_NS), .T_CHR_NS(T_CHR_NS), .T_RAS_NS(T_RAS_NS),
    .T_RP_NS(T_RP_NS), .T_RPC_NS(T_RPC_NS), .INIT_REFS(INIT_REFS), .OWED_W(OWED_W)
  ) u_dram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .ref_req(ref_req), .ref_grant(ref_grant),
    .ref_done(ref_done), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .init_ready(init_ready)
  );

  always #10 clk = ~clk;

  int n_run = 0, n_fail = 0, cyc = 0;
  int fall_cnt = 0, done_cnt = 0;
  int ras_low_run = 0, ras_high_run = 1000, cas_low_run = 0;
  bit prev_ras = 1, prev_cas = 1, cas_ok = 1, req_early = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // strobe monitor on every refresh
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ras && !ras_n) begin
        fall_cnt++;
        chk(cas_low_run >= csr_c, "R3 cas lead", cas_low_run, csr_c);
        chk(lcas_n == ucas_n, "R3 byte strobes equal", int'(lcas_n), int'(ucas_n));
        chk(ras_high_run >= rp_c, "R5 ras precharge", ras_high_run, rp_c);
        cas_ok = 1;
      end
      if (!prev_ras && ras_n)
        chk(ras_low_run >= act_c && cas_ok, "R4 ras low width", ras_low_run, act_c);
      if (!prev_cas && lcas_n)
        chk(ras_high_run >= rpc_c, "R5 cas release", ras_high_run, rpc_c);
      if (!ras_n && lcas_n) cas_ok = 0;
      ras_low_run  = ras_n ? 0 : ras_low_run + 1;
      ras_high_run = ras_n ? ras_high_run + 1 : 0;
      cas_low_run  = lcas_n ? 0 : cas_low_run + 1;
      if (ref_req && !init_ready) req_early = 1;
      if (ref_done) done_cnt++;
      prev_ras = ras_n;
      prev_cas = lcas_n;
    end
  end

  initial begin
    #100us;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int ready_cyc, f0, d0;
    csr_c = c_of(T_CSR_NS);
    act_c = (c_of(T_RAS_NS) > c_of(T_CHR_NS)) ? c_of(T_RAS_NS) : c_of(T_CHR_NS);
    rp_c  = c_of(T_RP_NS);
    rpc_c = c_of(T_RPC_NS);
    per_c = 1 + csr_c + act_c + rp_c;
    owed_max = (1 << OWED_W) - 1;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras_n && lcas_n && ucas_n, "R1 strobes high", int'(ras_n), 1);
    chk(!ref_req && !ref_done && !init_ready, "R1 flags low", int'(init_ready), 0);
    rst_n = 1;

    // R2 bring-up
    while (!init_ready) @(negedge clk);
    ready_cyc = cyc;
    chk(ready_cyc == PW_C + INIT_REFS * per_c, "R2 ready time", ready_cyc, PW_C + INIT_REFS * per_c);
    chk(fall_cnt == INIT_REFS, "R2 init refresh count", fall_cnt, INIT_REFS);
    chk(!req_early, "R2 no early request", int'(req_early), 0);

    // R6/R7/R8 latency sweep
    for (int lat = 0; lat < 5; lat++) begin
      while (!ref_req) @(negedge clk);
      chk(cyc == ready_cyc + INT_C * (lat + 1), "R6 request time", cyc, ready_cyc + INT_C * (lat + 1));
      repeat (lat) begin
        @(negedge clk);
        chk(ref_req && ras_n, "R7 request held", int'(ref_req), 1);
      end
      ref_grant = 1;
      @(negedge clk);
      ref_grant = 0;
      chk(!ref_req, "R8 no request while busy", int'(ref_req), 0);
      repeat (per_c - 3) @(negedge clk);
      chk(!ref_done, "R8 done not early", int'(ref_done), 0);
      @(negedge clk);
      chk(ref_done, "R8 done on time", int'(ref_done), 1);
      @(negedge clk);
      chk(!ref_done, "R8 done single", int'(ref_done), 0);
    end

    // R7 grant without request is ignored
    f0 = fall_cnt;
    ref_grant = 1;
    repeat (5) @(negedge clk);
    ref_grant = 0;
    chk(fall_cnt == f0, "R7 stray grant", fall_cnt, f0);

    // R9 backlog of three served back to back
    while (cyc < ready_cyc + 8 * INT_C + 2) @(negedge clk);
    d0 = done_cnt;
    ref_grant = 1;
    repeat (3 * per_c + 4) @(negedge clk);
    ref_grant = 0;
    chk(done_cnt - d0 == 3, "R9 backlog served", done_cnt - d0, 3);
    chk(!ref_req, "R9 request cleared", int'(ref_req), 0);

    // R9 saturation: five missed, capacity kept
    while (cyc < ready_cyc + 13 * INT_C + 2) @(negedge clk);
    d0 = done_cnt;
    ref_grant = 1;
    repeat (owed_max * per_c + 6) @(negedge clk);
    ref_grant = 0;
    chk(done_cnt - d0 == owed_max, "R9 saturated backlog", done_cnt - d0, owed_max);
    chk(!ref_req, "R9 request cleared after saturation", int'(ref_req), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule